// File: doc/BRIEF.md
# Parallel EEPROM Host Controller

This block sits between a synchronous command source and an asynchronous 128K x 8 parallel EEPROM. It turns single-beat read and write commands into chip-enable, output-enable and write-enable strobe sequences whose setup, strobe and hold phases each last a programmable number of clocks. The address bus and the data bus have separate output and input pins, plus an enable that drives the bidirectional data pads. Writes can be grouped into a burst that stays inside one 64-byte page. A burst ends with a byte flagged as last. Once the last byte is in, the controller polls the device until its internal program cycle ends, and reports a timeout if polling never succeeds.

Control is one state machine. `ST_IDLE` accepts any command: a read goes to `ST_RD_SETUP` and a write goes to `ST_WR_SETUP`. A read then passes through `ST_RD_SETUP` → `ST_RD_STROBE` → `ST_RD_HOLD` → `ST_IDLE`. A write passes through `ST_WR_SETUP` → `ST_WR_STROBE` → `ST_WR_HOLD`. From there it goes to `ST_BURST` if the byte was not last, or to `ST_PL_SETUP` if it was. `ST_BURST` waits for the next write of the same page; a matching write goes to `ST_WR_SETUP`, and a write to another page is answered at once and the state machine stays in `ST_BURST`. Polling loops through `ST_PL_SETUP` → `ST_PL_STROBE` → `ST_PL_HOLD`, and leaves `ST_PL_HOLD` for `ST_IDLE` on success or on timeout. In every other case `ST_PL_HOLD` returns to `ST_PL_SETUP`.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: During and after reset, all three strobes are high, the data drive enable is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A read holds chip-enable low for setup+strobe+hold cycles and output-enable low for exactly the strobe cycles, with write-enable high. The data drive enable is never high while output-enable is low. `rsp_rdata` returns the bus value sampled in the last strobe cycle.
- R3: For a write, chip-enable falls exactly setup cycles before write-enable falls. The address does not change across the write-enable falling edge. Write-enable stays low for exactly the strobe cycles, and output-enable stays high.
- R4: Write data is driven and unchanged across the write-enable rising edge, with chip-enable still low. The drive enable stays high for exactly the hold cycles after that edge.
- R5: A setup, strobe or hold count of 0 acts as 1 cycle; any other value N gives N cycles.
- R6: Inside an open burst, a write whose address bits 16..6 differ from the burst's is answered with `rsp_err`=1 after one cycle. It produces no strobe, stores nothing and does not close the burst, even if it is flagged last.
- R7: While a burst is open, `cmd_ready` is low whenever `cmd_write`=0, so reads wait.
- R8: With `cfg_toggle_poll`=0, after the last byte the controller repeatedly reads the last written address. It finishes with `rsp_err`=0 on the first read whose bit 7 equals bit 7 of the written byte.
- R9: With `cfg_toggle_poll`=1, it finishes with `rsp_err`=0 on the first poll read whose bit 6 equals bit 6 of the poll read just before it. The first poll read never finishes.
- R10: If no poll read has succeeded when `TIMEOUT_CYC` cycles have passed since polling began, the poll read in progress completes and the write is answered with `rsp_err`=1.
- R11: From accepting a read or a last write until its response, `cmd_ready` stays low.
- R12: A write that is not last is answered with `rsp_err`=0 right after its hold phase, with no polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_last | input | 1 | Write ends the burst and starts polling |
| cmd_addr | input | 17 | Byte address |
| cmd_wdata | input | 8 | Write byte |
| cfg_setup | input | 4 | Setup phase length in cycles |
| cfg_strobe | input | 4 | Strobe phase length in cycles |
| cfg_hold | input | 4 | Hold phase length in cycles |
| cfg_toggle_poll | input | 1 | 1 = bit-6 toggle polling, 0 = bit-7 data polling |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Read result |
| rsp_err | output | 1 | Page violation or poll timeout |
| ee_ce_n | output | 1 | Chip enable, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write enable, active low |
| ee_addr | output | 17 | Device address |
| ee_dq_o | output | 8 | Data toward the pads |
| ee_dq_oe | output | 1 | Pad drive enable |
| ee_dq_i | input | 8 | Data from the pads |

## Verification
The hardest states to reach are the ends of polling, because they depend on how the device model answers over time, not on the command itself. The bench's device model stays busy for a chosen number of clocks after each write edge. While busy, it returns bit 7 either inverted or true, and it flips bit 6 on every output-enable fall. This lets a test force a case where data polling would finish at once but toggle polling must wait, and a case where the busy time exceeds the timeout. The open-burst states are reached by leaving the last flag clear and then offering a write to another page and a read.

// File: rtl/ee_host_pkg.sv
`timescale 1ns/1ps
package ee_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BURST,
        ST_RD_SETUP,
        ST_RD_STROBE,
        ST_RD_HOLD,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_PL_SETUP,
        ST_PL_STROBE,
        ST_PL_HOLD
    } ee_state_t;

endpackage

// File: rtl/ee_cycle_timer.sv
`timescale 1ns/1ps
module ee_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R5: phase lengths come from a steady countdown
    a_r5_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/ee_poll_judge.sv
`timescale 1ns/1ps
module ee_poll_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic toggle_mode,
    input  logic ref_b7,
    input  logic rd_b7,
    input  logic rd_b6,
    output logic hit
);

    logic prev_b6_q;
    logic have_prev_q;
    logic hit_q;
    logic match;

    always_comb begin
        if (toggle_mode) begin
            match = have_prev_q && (prev_b6_q == rd_b6);
        end else begin
            match = (rd_b7 == ref_b7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_b6_q   <= 1'b0;
            have_prev_q <= 1'b0;
            hit_q       <= 1'b0;
        end else if (clear) begin
            have_prev_q <= 1'b0;
            hit_q       <= 1'b0;
        end else if (sample) begin
            prev_b6_q   <= rd_b6;
            have_prev_q <= 1'b1;
            hit_q       <= match;
        end
    end

    assign hit = hit_q;

    // R9: toggle polling never succeeds on the first poll read
    a_r9_first_read_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && toggle_mode && !have_prev_q && !clear) |=> !hit_q);

endmodule

// File: rtl/eeprom_host_ctrl.sv
`timescale 1ns/1ps
module eeprom_host_ctrl
    import ee_host_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 64,
    parameter int CNT_W       = 4,
    parameter int TIMEOUT_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_last,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_toggle_poll,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              ee_ce_n,
    output logic              ee_oe_n,
    output logic              ee_we_n,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [DATA_W-1:0] ee_dq_o,
    output logic              ee_dq_oe,
    input  logic [DATA_W-1:0] ee_dq_i
);

    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam int TMO_W    = $clog2(TIMEOUT_CYC + 1);

    ee_state_t st_q, st_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;

    logic              ph_load;
    logic [CNT_W-1:0]  ph_val;
    logic              ph_done;
    logic              tmo_load;
    logic              tmo_done;
    logic              take;
    logic              rsp_set;
    logic              rsp_err_d;
    logic              rd_cap;
    logic              pl_sample;
    logic              pl_clear;
    logic              pl_hit;
    logic              page_same;

    assign page_same = (cmd_addr[ADDR_W-1:PAGE_LSB] == addr_q[ADDR_W-1:PAGE_LSB]);

    ee_cycle_timer #(.W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_done)
    );

    ee_cycle_timer #(.W(TMO_W)) u_poll_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmo_load),
        .load_val (TMO_W'(TIMEOUT_CYC)),
        .expired  (tmo_done)
    );

    ee_poll_judge u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (pl_clear),
        .sample      (pl_sample),
        .toggle_mode (cfg_toggle_poll),
        .ref_b7      (wdata_q[7]),
        .rd_b7       (ee_dq_i[7]),
        .rd_b6       (ee_dq_i[6]),
        .hit         (pl_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and phase control
    always_comb begin
        st_d      = st_q;
        ph_load   = 1'b0;
        ph_val    = cfg_setup;
        tmo_load  = 1'b0;
        take      = 1'b0;
        rsp_set   = 1'b0;
        rsp_err_d = 1'b0;
        rd_cap    = 1'b0;
        pl_sample = 1'b0;
        pl_clear  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    take    = 1'b1;
                    ph_load = 1'b1;
                    st_d    = cmd_write ? ST_WR_SETUP : ST_RD_SETUP;
                end
            end
            ST_BURST: begin
                if (cmd_valid && cmd_write) begin
                    if (page_same) begin
                        take    = 1'b1;
                        ph_load = 1'b1;
                        st_d    = ST_WR_SETUP;
                    end else begin
                        rsp_set   = 1'b1;
                        rsp_err_d = 1'b1;
                    end
                end
            end
            ST_RD_SETUP: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    ph_val  = cfg_strobe;
                    st_d    = ST_RD_STROBE;
                end
            end
            ST_RD_STROBE: begin
                if (ph_done) begin
                    rd_cap  = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = cfg_hold;
                    st_d    = ST_RD_HOLD;
                end
            end
            ST_RD_HOLD: begin
                if (ph_done) begin
                    rsp_set = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    ph_val  = cfg_strobe;
                    st_d    = ST_WR_STROBE;
                end
            end
            ST_WR_STROBE: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    ph_val  = cfg_hold;
                    st_d    = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (ph_done) begin
                    if (last_q) begin
                        ph_load  = 1'b1;
                        tmo_load = 1'b1;
                        pl_clear = 1'b1;
                        st_d     = ST_PL_SETUP;
                    end else begin
                        rsp_set = 1'b1;
                        st_d    = ST_BURST;
                    end
                end
            end
            ST_PL_SETUP: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    ph_val  = cfg_strobe;
                    st_d    = ST_PL_STROBE;
                end
            end
            ST_PL_STROBE: begin
                if (ph_done) begin
                    pl_sample = 1'b1;
                    ph_load   = 1'b1;
                    ph_val    = cfg_hold;
                    st_d      = ST_PL_HOLD;
                end
            end
            ST_PL_HOLD: begin
                if (ph_done) begin
                    if (pl_hit) begin
                        rsp_set = 1'b1;
                        st_d    = ST_IDLE;
                    end else if (tmo_done) begin
                        rsp_set   = 1'b1;
                        rsp_err_d = 1'b1;
                        st_d      = ST_IDLE;
                    end else begin
                        ph_load = 1'b1;
                        st_d    = ST_PL_SETUP;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // strobes and handshake
    always_comb begin
        ee_ce_n   = 1'b1;
        ee_oe_n   = 1'b1;
        ee_we_n   = 1'b1;
        ee_dq_oe  = 1'b0;
        cmd_ready = 1'b0;
        unique case (st_q)
            ST_IDLE:      cmd_ready = 1'b1;
            ST_BURST:     cmd_ready = cmd_write;
            ST_RD_SETUP,
            ST_RD_HOLD,
            ST_PL_SETUP,
            ST_PL_HOLD:   ee_ce_n = 1'b0;
            ST_RD_STROBE,
            ST_PL_STROBE: begin
                ee_ce_n = 1'b0;
                ee_oe_n = 1'b0;
            end
            ST_WR_SETUP,
            ST_WR_HOLD: begin
                ee_ce_n  = 1'b0;
                ee_dq_oe = 1'b1;
            end
            ST_WR_STROBE: begin
                ee_ce_n  = 1'b0;
                ee_we_n  = 1'b0;
                ee_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    // command capture and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            last_q      <= 1'b0;
            rdata_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            if (take) begin
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
                last_q  <= cmd_last;
            end
            if (rd_cap) begin
                rdata_q <= ee_dq_i;
            end
            rsp_valid_q <= rsp_set;
            if (rsp_set) begin
                rsp_err_q <= rsp_err_d;
            end
        end
    end

    assign ee_addr   = addr_q;
    assign ee_dq_o   = wdata_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rdata_q;
    assign rsp_err   = rsp_err_q;

    // R2: pads are released whenever the device may drive
    a_r2_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_oe_n |-> !ee_dq_oe);

    // R3: address and chip enable settled before the write-enable fall
    a_r3_addr_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_we_n) |-> ($stable(ee_addr) && !$past(ee_ce_n)));

    // R4: data still driven when write enable rises
    a_r4_data_through_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_we_n) |-> (ee_dq_oe && $stable(ee_dq_o) && !ee_ce_n));

    // R8: polling reads stay on the last written address
    a_r8_poll_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_PL_SETUP, ST_PL_STROBE, ST_PL_HOLD}) |-> $stable(ee_addr));

    // R11: responses only appear where a new command may be taken
    a_r11_rsp_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (st_q == ST_IDLE || st_q == ST_BURST));

endmodule

// File: tb/eeprom_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_host_ctrl_tb_top;

    localparam int AW  = 17;
    localparam int DW  = 8;
    localparam int CW  = 4;
    localparam int TMO = 300;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          cmd_valid, cmd_ready, cmd_write, cmd_last;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [CW-1:0] cfg_setup, cfg_strobe, cfg_hold;
    logic          cfg_toggle_poll;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
    logic [AW-1:0] ee_addr;
    logic [DW-1:0] ee_dq_o, ee_dq_i;

    eeprom_host_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(64), .CNT_W(CW), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_last(cmd_last), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_toggle_poll(cfg_toggle_poll), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
        .ee_addr(ee_addr), .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe), .ee_dq_i(ee_dq_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // device model: small memory, busy window after each write edge
    logic [7:0] mem [0:255];
    int         busy_n = 0;
    int         busy_len = 30;
    logic       inv7 = 1'b1;
    logic       tog = 1'b0;
    logic [7:0] last_d = 8'h00;
    logic       we_p = 1'b1, oe_p = 1'b1;

    always @(negedge clk) begin
        if (busy_n > 0) busy_n <= busy_n - 1;
        if (!we_p && ee_we_n && !ee_ce_n) begin
            mem[ee_addr[7:0]] <= ee_dq_o;
            last_d <= ee_dq_o;
            busy_n <= busy_len;
        end
        if (oe_p && !ee_oe_n) tog <= ~tog;
        we_p <= ee_we_n;
        oe_p <= ee_oe_n;
    end

    assign ee_dq_i = (!ee_ce_n && !ee_oe_n)
        ? ((busy_n > 0) ? {(inv7 ? ~last_d[7] : last_d[7]), tog, last_d[5:0]} : mem[ee_addr[7:0]])
        : 8'h00;

    // strobe monitor
    int ce_lo, oe_lo, we_lo;
    int t_ce_fall, t_we_rise, setup_gap, hold_gap;
    logic [AW-1:0] addr_p;
    logic [DW-1:0] do_p;
    logic doe_p = 1'b0, ce_m = 1'b1, we_m = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ee_ce_n) ce_lo++;
            if (!ee_oe_n) oe_lo++;
            if (!ee_we_n) we_lo++;
            if (ce_m && !ee_ce_n) t_ce_fall = cyc;
            if (we_m && !ee_we_n) begin
                setup_gap = cyc - t_ce_fall;
                chk(ee_addr == addr_p && !ce_m, "R3 address/chip-enable settled at write-enable fall", int'(ee_addr), int'(addr_p));
            end
            if (!we_m && ee_we_n) begin
                t_we_rise = cyc;
                chk(doe_p && ee_dq_oe && ee_dq_o == do_p && !ee_ce_n, "R4 data held at write-enable rise", int'(ee_dq_o), int'(do_p));
            end
            if (doe_p && !ee_dq_oe) hold_gap = cyc - t_we_rise;
            if (!ee_oe_n) chk(!ee_dq_oe, "R2 drive released while output enable low", int'(ee_dq_oe), 0);
        end
        addr_p = ee_addr;
        do_p   = ee_dq_o;
        doe_p  = ee_dq_oe;
        ce_m   = ee_ce_n;
        we_m   = ee_we_n;
    end

    int t_acc, t_rsp;

    task automatic send(input bit wr, input bit last, input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_lo = 0; oe_lo = 0; we_lo = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_last = last; cmd_addr = a; cmd_wdata = d;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        t_acc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int lim, output bit got, output bit err, output logic [DW-1:0] rd, output int rdy_hi);
        got = 1'b0; err = 1'b0; rd = '0; rdy_hi = 0;
        for (int i = 0; i < lim && !got; i++) begin
            if (rsp_valid) begin
                got = 1'b1; err = rsp_err; rd = rsp_rdata; t_rsp = cyc;
            end else begin
                if (cmd_ready) rdy_hi++;
                @(negedge clk);
            end
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [7:0] init_val(input int idx);
        return 8'((idx * 37 + 5) & 255);
    endfunction

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        bit g, e; logic [7:0] r; int rh;
        send(1'b0, 1'b0, a, 8'h00);
        wait_rsp(200, g, e, r, rh);
        chk(g && !e && r == exp, tag, int'(r), int'(exp));
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: cycles %0d expected below %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit g, e; logic [7:0] r; int rh;
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_last = 1'b0;
        cmd_addr = '0; cmd_wdata = '0; cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0;
        cfg_toggle_poll = 1'b0;
        repeat (3) @(negedge clk);
        chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe && !rsp_valid, "R1 strobes idle in reset", int'({ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe}), 14);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe && cmd_ready && !rsp_valid, "R1 idle after reset", int'(cmd_ready), 1);

        // R2 / R5: sweep every phase length 0..3 for reads
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int h = 0; h < 4; h++) begin
                    int idx;
                    idx = s * 16 + p * 4 + h;
                    cfg_setup = CW'(s); cfg_strobe = CW'(p); cfg_hold = CW'(h);
                    send(1'b0, 1'b0, AW'(17'h10000 + idx), 8'h00);
                    wait_rsp(100, g, e, r, rh);
                    chk(g && !e && r == init_val(idx), "R2 read data", int'(r), int'(init_val(idx)));
                    chk(oe_lo == eff(p) && we_lo == 0, "R5 output-enable width", oe_lo, eff(p));
                    chk(ce_lo == eff(s) + eff(p) + eff(h), "R5 chip-enable width", ce_lo, eff(s) + eff(p) + eff(h));
                    chk(rh == 0, "R11 ready low during read", rh, 0);
                end
            end
        end

        // R8: single-byte write, data polling
        cfg_setup = 4'd2; cfg_strobe = 4'd3; cfg_hold = 4'd1; cfg_toggle_poll = 1'b0;
        busy_len = 30; inv7 = 1'b1;
        send(1'b1, 1'b1, 17'h12345, 8'hA5);
        wait_rsp(3000, g, e, r, rh);
        chk(g && !e, "R8 data polling completes", int'(e), 0);
        chk(t_rsp - t_acc >= 30, "R8 completion waits for busy", t_rsp - t_acc, 30);
        chk(we_lo == 3, "R3 write-enable width", we_lo, 3);
        chk(setup_gap == 2, "R3 chip-enable to write-enable gap", setup_gap, 2);
        chk(hold_gap == 1, "R4 data hold after rise", hold_gap, 1);
        chk(rh == 0, "R11 ready low during write and poll", rh, 0);
        do_read(17'h12345, 8'hA5, "R4 written byte read back");

        // R9: toggle polling when bit 7 already looks finished
        cfg_toggle_poll = 1'b1; busy_len = 60; inv7 = 1'b0;
        send(1'b1, 1'b1, 17'h00777, 8'h3C);
        wait_rsp(3000, g, e, r, rh);
        chk(g && !e, "R9 toggle polling completes", int'(e), 0);
        chk(t_rsp - t_acc >= 60, "R9 toggle polling waits for bit 6 to settle", t_rsp - t_acc, 60);
        do_read(17'h00777, 8'h3C, "R9 written byte read back");

        // R10: device stays busy past the timeout
        cfg_toggle_poll = 1'b0; inv7 = 1'b1; busy_len = 2000;
        cfg_setup = 4'd1; cfg_strobe = 4'd1; cfg_hold = 4'd1;
        send(1'b1, 1'b1, 17'h00155, 8'h5A);
        wait_rsp(3000, g, e, r, rh);
        chk(g && e, "R10 timeout flagged", int'(e), 1);
        chk(t_rsp - t_acc >= TMO && t_rsp - t_acc <= TMO + 30, "R10 timeout moment", t_rsp - t_acc, TMO);
        repeat (2100) @(negedge clk);
        do_read(17'h00155, 8'h5A, "R10 byte stored despite timeout");

        // R6 / R7 / R12: page burst
        busy_len = 40;
        send(1'b1, 1'b0, 17'h00A40, 8'h11);
        wait_rsp(100, g, e, r, rh);
        chk(g && !e, "R12 non-last byte answered", int'(e), 0);
        chk(t_rsp - t_acc <= 8, "R12 no polling for non-last byte", t_rsp - t_acc, 8);
        send(1'b1, 1'b0, 17'h00A41, 8'h22);
        wait_rsp(100, g, e, r, rh);
        chk(g && !e, "R12 second byte answered", int'(e), 0);
        send(1'b1, 1'b1, 17'h00A80, 8'h99);
        wait_rsp(10, g, e, r, rh);
        chk(g && e, "R6 other page rejected", int'(e), 1);
        chk(we_lo == 0 && ce_lo == 0, "R6 no strobe for rejected byte", we_lo + ce_lo, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 17'h00A40;
        #1;
        chk(!cmd_ready, "R7 read held off in open burst", int'(cmd_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(!cmd_ready && !rsp_valid && ee_ce_n, "R7 read still held off", int'(cmd_ready), 0);
        cmd_valid = 1'b0;
        send(1'b1, 1'b1, 17'h00A7F, 8'h44);
        wait_rsp(3000, g, e, r, rh);
        chk(g && !e, "R8 burst closes after polling", int'(e), 0);
        do_read(17'h00A40, 8'h11, "R6 first page byte");
        do_read(17'h00A41, 8'h22, "R6 second page byte");
        do_read(17'h00A7F, 8'h44, "R6 last page byte");
        do_read(17'h00A80, init_val(8'h80), "R6 rejected byte not stored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule